// File: doc/BRIEF.md
# Configurable Edge-Trigger Event Detector

This block watches a small, sparse set of event lines and turns selected transitions on them into sticky pending flags, a level interrupt and single-cycle event pulses. Each implemented line has a rising-edge enable and a falling-edge enable. Software programs these enables through a simple synchronous register port. Each line is compared against the value it had on the previous clock. When an enabled transition is seen, the line's pending flag is set and stays set until software clears it.

Event lines sit on a 32-bit input vector at the same bit position as their enable and pending bits. Only positions 13, 9, 8 and 2 hold real logic. Every other position is reserved: it never triggers, ignores writes and reads back as zero. A transition that lands in the same clock as a write to either enable register is thrown away, so reprogramming the enables can never produce a spurious flag.

Top module: `edgeTrigUnit`

## Requirements
- R1: After reset, both enable registers and the pending register read 0, `irq` is 0 and `eventPulse` is 0.
- R2: The rising-enable register is at address 0x20, the falling-enable register at 0x24 and the pending register at 0x28. `rdData` shows the addressed register combinationally, and shows 0 for any other address. Only bits 13, 9, 8 and 2 are implemented. All other bits read 0, ignore writes and never set a pending bit or an event pulse.
- R3: When a line's rising enable is 1 and the line goes from 0 to 1 between two clock samples, its pending bit is 1 from the clock edge that samples the new value.
- R4: When a line's falling enable is 1, a 1-to-0 transition sets its pending bit with the same timing as R3.
- R5: When both enables are set for a line, either transition sets its pending bit.
- R6: A transition on a line whose matching enable is 0 sets nothing. A level that is held produces no trigger after its first edge.
- R7: A transition that is sampled in the same clock as a write to address 0x20 or 0x24 sets no pending bit on any line.
- R8: Writing 1 to a pending bit at 0x28 clears it, and writing 0 leaves it unchanged. If a new trigger arrives in the same clock as a clear, the bit stays 1.
- R9: `irq` is 1 exactly when at least one pending bit is 1.
- R10: Each trigger drives the matching `eventPulse` bit high for exactly the one cycle in which its pending bit is first set by that trigger.
- R11: A line that is already high when reset is released produces no trigger while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| evtIn | input | 32 | Event lines, one per bit position |
| eventPulse | output | 32 | One-cycle trigger pulses |
| irq | output | 1 | OR of all pending bits |

## Verification
The hardest case to reach is the collision rule. A line has to change in exactly the clock in which an enable register is written, and the same must hold for a pending clear meeting a fresh edge. The stimulus tasks drive the write strobe and the event vector together in a single step, so both land on the same sampling edge. The reference model then decides from the requirements which of the two wins. A random phase adds further toggles on implemented and reserved bits, mixed with writes, and the model is compared on every clock.

// File: rtl/edgeTrigPkg.sv
package edgeTrigPkg;
  localparam int RISE_OFS = 'h20;
  localparam int FALL_OFS = 'h24;
  localparam int PEND_OFS = 'h28;

  typedef struct packed {
    logic wrRise;
    logic wrFall;
    logic wrPend;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_PEND = 2'd3
  } rdSel_t;
endpackage

// File: rtl/etgCtrl.sv
module etgCtrl
  import edgeTrigPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strb,
  output rdSel_t            rdSel
);
  localparam logic [ADDR_W-1:0] RiseAddr = ADDR_W'(RISE_OFS);
  localparam logic [ADDR_W-1:0] FallAddr = ADDR_W'(FALL_OFS);
  localparam logic [ADDR_W-1:0] PendAddr = ADDR_W'(PEND_OFS);

  logic hitRise, hitFall, hitPend;

  assign hitRise = (addr == RiseAddr);
  assign hitFall = (addr == FallAddr);
  assign hitPend = (addr == PendAddr);

  always_comb begin
    strb.wrRise = wrEn && hitRise;
    strb.wrFall = wrEn && hitFall;
    strb.wrPend = wrEn && hitPend;
  end

  always_comb begin
    if (hitRise)      rdSel = SEL_RISE;
    else if (hitFall) rdSel = SEL_FALL;
    else if (hitPend) rdSel = SEL_PEND;
    else              rdSel = SEL_NONE;
  end
endmodule

// File: rtl/etgDatapath.sv
module etgDatapath
  import edgeTrigPkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter logic [DATA_W-1:0]  IMPL_MASK = 32'h0000_2304
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pendVec,
  output logic [DATA_W-1:0] eventPulse,
  output logic              irq
);
  logic [DATA_W-1:0] riseVec, fallVec;
  logic blockEdge;
  logic unusedBits;

  // a write to either enable register swallows every edge in that cycle
  assign blockEdge  = strb.wrRise || strb.wrFall;
  assign unusedBits = ^{evtIn & ~IMPL_MASK, wrData & ~IMPL_MASK};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic riseQ, fallQ, prevQ, pendQ, pulseQ, trig;

      assign trig = !blockEdge &&
                    ((riseQ && evtIn[i] && !prevQ) ||
                     (fallQ && !evtIn[i] && prevQ));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          riseQ  <= 1'b0;
          fallQ  <= 1'b0;
          prevQ  <= 1'b0;
          pendQ  <= 1'b0;
          pulseQ <= 1'b0;
        end else begin
          prevQ  <= evtIn[i];
          pulseQ <= trig;
          if (strb.wrRise) riseQ <= wrData[i];
          if (strb.wrFall) fallQ <= wrData[i];
          // new trigger takes priority over a write-one clear
          if (trig)                          pendQ <= 1'b1;
          else if (strb.wrPend && wrData[i]) pendQ <= 1'b0;
        end
      end

      assign riseVec[i]    = riseQ;
      assign fallVec[i]    = fallQ;
      assign pendVec[i]    = pendQ;
      assign eventPulse[i] = pulseQ;
    end else begin : g_rsv
      assign riseVec[i]    = 1'b0;
      assign fallVec[i]    = 1'b0;
      assign pendVec[i]    = 1'b0;
      assign eventPulse[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_RISE: rdData = riseVec;
      SEL_FALL: rdData = fallVec;
      SEL_PEND: rdData = pendVec;
      default:  rdData = '0;
    endcase
  end

  assign irq = |pendVec;
endmodule

// File: rtl/edgeTrigUnit.sv
module edgeTrigUnit
  import edgeTrigPkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0000_2304
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0] eventPulse,
  output logic              irq
);
  ctrlStrobe_t       strb;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] pendVec;

  etgCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  etgDatapath #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (rdSel),
    .wrData     (wrData),
    .evtIn      (evtIn),
    .rdData     (rdData),
    .pendVec    (pendVec),
    .eventPulse (eventPulse),
    .irq        (irq)
  );
endmodule

// File: rtl/etgChecker.sv
module etgChecker
  import edgeTrigPkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0000_2304
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] evtIn,
  input logic [DATA_W-1:0] eventPulse,
  input logic [DATA_W-1:0] pendVec,
  input logic              irq
);
  logic cfgWrite;
  assign cfgWrite = wrEn && (addr == ADDR_W'(RISE_OFS) || addr == ADDR_W'(FALL_OFS));

  // R10: a pulse always comes with the matching pending bit and the interrupt
  a_r10_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    ((eventPulse & ~pendVec) == '0) && ((eventPulse != '0) -> irq));

  // R7: an edge sampled during an enable write produces no pulse
  a_r7_cfg_write_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (eventPulse == '0));

  // R2: reserved positions stay quiet
  a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~IMPL_MASK) == '0) && ((eventPulse & ~IMPL_MASK) == '0));

  // R6: a held level produces no pulse
  a_r6_held_level: assert property (@(posedge clk) disable iff (!rstN)
    $stable(evtIn) |=> (eventPulse == '0));

  // R8: a pending bit only falls during a pending-register write
  a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~$past(pendVec)) == '0 && $fell(irq)) |-> $past(wrEn && addr == ADDR_W'(PEND_OFS)));
endmodule

bind edgeTrigUnit etgChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)
) i_etgChecker (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .evtIn      (evtIn),
  .eventPulse (eventPulse),
  .pendVec    (pendVec),
  .irq        (irq)
);

// File: tb/test_edgeTrigUnit.sv
`timescale 1ns/1ps
module test_edgeTrigUnit;
  localparam logic [31:0] MASK = 32'h0000_2304;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h28;
  logic [31:0] wrData = '0;
  logic [31:0] evtIn = 32'h0000_2000;
  logic [31:0] rdData, eventPulse;
  logic        irq;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  logic  armed = 1'b0;

  logic [31:0] mRise, mFall, mPend, mPrev, mPulse;

  always #10 clk = ~clk;

  edgeTrigUnit i_edgeTrigUnit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .eventPulse(eventPulse), .irq(irq)
  );

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRise = 0; mFall = 0; mPend = 0; mPrev = 0; mPulse = 0;
    end else begin
      logic [31:0] trig, clr;
      bit blocked;
      trig = 0;
      blocked = wrEn && (addr == 8'h20 || addr == 8'h24);
      for (int i = 0; i < 32; i++) begin
        if (MASK[i] && !blocked) begin
          if (mRise[i] && evtIn[i] && !mPrev[i]) trig[i] = 1'b1;
          if (mFall[i] && !evtIn[i] && mPrev[i]) trig[i] = 1'b1;
        end
      end
      clr = (wrEn && addr == 8'h28) ? wrData : 32'h0;
      mPend = ((mPend & ~clr) | trig) & MASK;
      mPulse = trig;
      if (wrEn && addr == 8'h20) mRise = wrData & MASK;
      if (wrEn && addr == 8'h24) mFall = wrData & MASK;
      mPrev = evtIn;
    end
  end

  function automatic logic [31:0] modelRd(input logic [7:0] a);
    case (a)
      8'h20:   return mRise;
      8'h24:   return mFall;
      8'h28:   return mPend;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      check("irq", {31'b0, irq}, {31'b0, mPend != 0});
      check("eventPulse", eventPulse, mPulse);
      check("rdData", rdData, modelRd(addr));
    end
  end

  task automatic step(input logic [31:0] e, input logic [7:0] a);
    @(posedge clk); #5;
    wrEn = 1'b0; evtIn = e; addr = a;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] e);
    @(posedge clk); #5;
    wrEn = 1'b1; addr = a; wrData = d; evtIn = e;
    @(posedge clk); #5;
    wrEn = 1'b0; addr = 8'h28;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int k = 0; k < n; k++) step(evtIn, a);
  endtask

  initial begin
    armed = 1'b1;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    curReq = "R1";  idle(2, 8'h20); idle(2, 8'h24); idle(2, 8'h28);
    // R11: bit 13 was high through reset
    curReq = "R11"; wr(8'h20, 32'hFFFF_FFFF, evtIn); idle(4, 8'h28);
    // R2: only implemented bits stick, reserved lines never trigger
    curReq = "R2";  idle(1, 8'h20); wr(8'h24, 32'hFFFF_FFFF, evtIn); idle(1, 8'h24);
    idle(1, 8'h30); wr(8'h24, 32'h0, evtIn);
    step(evtIn ^ 32'h8000_0021, 8'h28); step(evtIn ^ 32'h8000_0021, 8'h28); idle(2, 8'h28);
    // R3: rising on lines at bits 2 and 8
    curReq = "R3";  step(evtIn | 32'h0000_0104, 8'h28); idle(2, 8'h28);
    curReq = "R6";  idle(5, 8'h28);
    // R8: write-one clear, write-zero no effect, set beats clear
    curReq = "R8";  wr(8'h28, 32'h0000_0004, evtIn); idle(1, 8'h28);
    wr(8'h28, 32'h0, evtIn); idle(1, 8'h28);
    wr(8'h28, 32'h0000_0200, evtIn | 32'h0000_0200); idle(2, 8'h28);
    wr(8'h28, 32'hFFFF_FFFF, evtIn); idle(1, 8'h28);
    // R4: falling only
    curReq = "R4";  wr(8'h20, 32'h0, evtIn); wr(8'h24, 32'hFFFF_FFFF, evtIn);
    step(evtIn & ~32'h0000_2000, 8'h28); idle(1, 8'h28);
    curReq = "R6";  step(evtIn | 32'h0000_2000, 8'h28); idle(2, 8'h28);
    wr(8'h28, 32'hFFFF_FFFF, evtIn);
    // R5: both edges on bit 8
    curReq = "R5";  wr(8'h20, 32'h0000_2304, evtIn);
    step(evtIn & ~32'h0000_0100, 8'h28); idle(1, 8'h28);
    wr(8'h28, 32'h0000_0100, evtIn); step(evtIn | 32'h0000_0100, 8'h28); idle(2, 8'h28);
    wr(8'h28, 32'hFFFF_FFFF, evtIn); idle(1, 8'h28);
    // R7: edges landing on enable-register writes are dropped
    curReq = "R7";  wr(8'h20, 32'h0000_2304, evtIn ^ 32'h0000_0004); idle(2, 8'h28);
    wr(8'h24, 32'h0000_2304, evtIn ^ 32'h0000_2204); idle(2, 8'h28);
    // R9 and R10: random traffic
    curReq = "R10";
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (n == 150) curReq = "R9";
      if (r == 0)      wr(8'h28, $urandom, evtIn ^ ($urandom & 32'h0000_2304));
      else if (r == 1) wr(8'h20, $urandom, evtIn ^ ($urandom & 32'h0000_2305));
      else if (r == 2) wr(8'h24, $urandom, evtIn);
      else             step(evtIn ^ ($urandom & 32'h0001_2384), 8'h28);
    end
    idle(2, 8'h28);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule